// File: doc/BRIEF.md
# Configurable Look-Up-Table Function Unit

The block models a single programmable logic tile. Four 16-entry look-up tables and four output storage elements sit behind one set of data pins: two 5-bit operand buses, a 4-bit write-data bus, a general control input, a clock with clock enable, a force-to-initial-value input and a carry input. A 5-bit result bus and a carry output come back. A serial shift port fills a 72-bit configuration word. That word holds the table contents and picks how the tables are used: as independent logic functions of four, five or six inputs, as a 4-bit carry-chained adder, or as a small RAM.

In RAM mode the tables form either a 16x4 single-port memory or a 16x2 memory with a second independent read port. Writes can be synchronous, or write-through, where the written data is visible at once. The four storage elements either register the result or are bypassed. A configuration bit decides whether they are forced to a configured value synchronously or asynchronously.

Top module: `lut_tile`

## Requirements
- R1: While `rst_n` is low, the configuration word and the storage elements are cleared. `dout` and `carry_out` read 0 both during reset and after it is released.
- R2: Each rising `clk` edge with `cfg_shift` high shifts the configuration word left by one bit, with `cfg_bit` entering bit 0. A full load therefore sends the word most significant bit first. The word layout is as follows:
  - Bits [63:0] hold the tables, with table k entry i at bit 16k+i.
  - Bits [65:64] select the mode: 0 logic, 1 adder, 2 single-port RAM, 3 dual-port RAM.
  - Bits [67:66] select the function width: 0 four-input, 1 five-input, 2 or 3 six-input.
  - Bit 68 bypasses the registers.
  - Bit 69 makes the force input asynchronous.
  - Bit 70 is the forced value.
  - Bit 71 selects write-through.
- R3: The logic mode has three function widths.
  - Four-input: result bits 0 and 1 are tables 0 and 1 addressed by `in_a[3:0]`, and bits 2 and 3 are tables 2 and 3 addressed by `in_b[3:0]`.
  - Five-input: bit 0 is table 1 if `in_a[4]` is set, else table 0, both addressed by `in_a[3:0]`. Bit 1 is table 3 if `in_b[4]` is set, else table 2, both addressed by `in_b[3:0]`. Bits 2 and 3 are 0.
  - Six-input: bit 0 is table {`in_b[4]`,`in_a[4]`} addressed by `in_a[3:0]`, and bits 1 to 3 are 0.
  - In all three widths `dout[4]` carries unregistered result bit 0.
- R4: In adder mode, {`carry_out`,result[3:0]} equals `in_a[3:0]` + `in_b[3:0]` + `carry_in`, whatever the table contents. `dout[4]` is 0.
- R5: With bypass clear, `dout[3:0]` shows the storage elements. They load the result on a rising edge with `clk_en` high and hold when it is low. With bypass set, `dout[3:0]` is the unregistered result.
- R6: With the synchronous style, `force_init` high loads the forced value into all four elements at the next rising edge, even if `clk_en` is low.
- R7: With the asynchronous style, `force_init` high sets all four elements to the forced value without a clock edge.
- R8: In single-port RAM mode, the result is table k at `in_a[3:0]` for bit k. A rising edge with `ctl_sel` high writes `wr_data` to that address. With `ctl_sel` low the contents do not change.
- R9: With write-through selected, while `ctl_sel` is high the read data at the write address equals `wr_data` before the clock edge.
- R10: In dual-port RAM mode, result bits [1:0] read tables 0 and 1 at `in_a[3:0]`. Bits [3:2] read tables 2 and 3 at `in_b[3:0]`. A write stores `wr_data[1:0]` at `in_a[3:0]` in both table pairs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset |
| clk | input | 1 | Tile clock |
| clk_en | input | 1 | Clock enable of the storage elements |
| force_init | input | 1 | Forces the storage elements to the configured value |
| ctl_sel | input | 1 | RAM write enable |
| in_a | input | 5 | Operand A / RAM write-read address |
| in_b | input | 5 | Operand B / second read address |
| wr_data | input | 4 | RAM write data |
| carry_in | input | 1 | Adder carry input |
| cfg_shift | input | 1 | Configuration shift enable |
| cfg_bit | input | 1 | Configuration serial data |
| dout | output | 5 | Result bus |
| carry_out | output | 1 | Adder carry output |

## Verification
The hardest conditions to reach are the ones visible only between clock edges. These are the asynchronous force in R7 and the write-through read in R9, and both are masked by the next edge. To reach them, the bench reloads the configuration with the matching style bits, changes only the force or write-enable pin half a period before an edge, and samples shortly after. For dual-port RAM, data written through port A must reappear on port B's bits. The bench checks this by first reading the address through B from preloaded table contents, then writing it and reading it again.

// File: rtl/lut_tile_pkg.sv
package lut_tile_pkg;
  localparam int NUM_LUT = 4;

  typedef enum logic [1:0] {
    MODE_LOGIC  = 2'd0,
    MODE_ADDER  = 2'd1,
    MODE_RAM    = 2'd2,
    MODE_RAM_DP = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    FN_FOUR = 2'd0,
    FN_FIVE = 2'd1,
    FN_SIX  = 2'd2,
    FN_SIXB = 2'd3
  } width_e;

  typedef struct packed {
    logic   wr_through;
    logic   init_val;
    logic   force_async;
    logic   bypass;
    width_e width;
    mode_e  mode;
  } ctrl_t;
endpackage

// File: rtl/lut_tile_cfg.sv
module lut_tile_cfg
  import lut_tile_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             cfg_shift,
  input  logic                             cfg_bit,
  input  logic                             wr_en,
  input  logic [ADDR_W-1:0]                wr_addr,
  input  logic [NUM_LUT-1:0]               wr_data,
  output logic [NUM_LUT*(1<<ADDR_W)-1:0]   lut_bits,
  output ctrl_t                            ctrl
);
  localparam int DEPTH    = 1 << ADDR_W;
  localparam int LUT_BITS = NUM_LUT * DEPTH;
  localparam int CTRL_W   = $bits(ctrl_t);
  localparam int CFG_W    = LUT_BITS + CTRL_W;
  localparam int HALF     = NUM_LUT / 2;

  logic [CFG_W-1:0] cfg_q, cfg_d;
  ctrl_t            ctrl_q;

  assign ctrl_q   = ctrl_t'(cfg_q[CFG_W-1 -: CTRL_W]);
  assign ctrl     = ctrl_q;
  assign lut_bits = cfg_q[LUT_BITS-1:0];

  // next state: shifting has priority over RAM writes
  always_comb begin
    cfg_d = cfg_q;
    if (cfg_shift) begin
      cfg_d = {cfg_q[CFG_W-2:0], cfg_bit};
    end else if (wr_en && ctrl_q.mode == MODE_RAM) begin
      for (int k = 0; k < NUM_LUT; k++)
        cfg_d[k*DEPTH + int'(wr_addr)] = wr_data[k];
    end else if (wr_en && ctrl_q.mode == MODE_RAM_DP) begin
      for (int k = 0; k < HALF; k++) begin
        cfg_d[k*DEPTH + int'(wr_addr)]        = wr_data[k];
        cfg_d[(k+HALF)*DEPTH + int'(wr_addr)] = wr_data[k];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  assert_shift_in_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_shift |=> (cfg_q[0] == $past(cfg_bit)));

  assert_ram_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_shift && wr_en && ctrl_q.mode == MODE_RAM)
      |=> (cfg_q[int'($past(wr_addr))] == $past(wr_data[0])));

  assert_dp_mirror_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_shift && wr_en && ctrl_q.mode == MODE_RAM_DP)
      |=> (cfg_q[HALF*DEPTH + int'($past(wr_addr))] == $past(wr_data[0])));
endmodule

// File: rtl/lut_tile_logic.sv
module lut_tile_logic
  import lut_tile_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic [NUM_LUT*(1<<ADDR_W)-1:0] lut_bits,
  input  ctrl_t                          ctrl,
  input  logic [ADDR_W:0]                op_a,
  input  logic [ADDR_W:0]                op_b,
  input  logic [NUM_LUT-1:0]             wdata,
  input  logic                           wr_en,
  input  logic                           cin,
  output logic [NUM_LUT-1:0]             res,
  output logic                           aux,
  output logic                           cout
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int HALF  = NUM_LUT / 2;

  logic [ADDR_W-1:0]  addr_a, addr_b;
  logic [NUM_LUT-1:0] rd_a, rd_b;
  logic [NUM_LUT:0]   carry;
  logic [NUM_LUT-1:0] sum;
  logic               wt_hit;

  assign addr_a = op_a[ADDR_W-1:0];
  assign addr_b = op_b[ADDR_W-1:0];

  // each table read at both addresses
  for (genvar k = 0; k < NUM_LUT; k++) begin : g_tbl
    logic [DEPTH-1:0] tbl;
    assign tbl     = lut_bits[k*DEPTH +: DEPTH];
    assign rd_a[k] = tbl[addr_a];
    assign rd_b[k] = tbl[addr_b];
  end

  // ripple carry chain for adder mode
  assign carry[0] = cin;
  for (genvar k = 0; k < NUM_LUT; k++) begin : g_chain
    assign sum[k]     = op_a[k] ^ op_b[k] ^ carry[k];
    assign carry[k+1] = (op_a[k] & op_b[k]) | (carry[k] & (op_a[k] ^ op_b[k]));
  end

  assign wt_hit = ctrl.wr_through && wr_en;

  always_comb begin
    res  = '0;
    aux  = 1'b0;
    cout = 1'b0;
    unique case (ctrl.mode)
      MODE_LOGIC: begin
        unique case (ctrl.width)
          FN_FOUR: begin
            res[0] = rd_a[0];
            res[1] = rd_a[1];
            res[2] = rd_b[2];
            res[3] = rd_b[3];
          end
          FN_FIVE: begin
            res[0] = op_a[ADDR_W] ? rd_a[1] : rd_a[0];
            res[1] = op_b[ADDR_W] ? rd_b[3] : rd_b[2];
          end
          default: res[0] = rd_a[{op_b[ADDR_W], op_a[ADDR_W]}];
        endcase
        aux = res[0];
      end
      MODE_ADDER: begin
        res  = sum;
        cout = carry[NUM_LUT];
      end
      MODE_RAM: begin
        res = wt_hit ? wdata : rd_a;
      end
      default: begin
        for (int k = 0; k < HALF; k++) begin
          res[k]      = wt_hit ? wdata[k] : rd_a[k];
          res[k+HALF] = (wt_hit && addr_b == addr_a) ? wdata[k] : rd_b[k+HALF];
        end
      end
    endcase
  end
endmodule

// File: rtl/lut_tile_regs.sv
module lut_tile_regs #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clk_en,
  input  logic         force_init,
  input  logic         force_async,
  input  logic         init_val,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0] q_d;
  logic         async_set;

  assign async_set = force_init & force_async;

  always_comb begin
    q_d = q;
    if (force_init)  q_d = {N{init_val}};
    else if (clk_en) q_d = d;
  end

  always_ff @(posedge clk or negedge rst_n or posedge async_set) begin
    if (!rst_n)         q <= '0;
    else if (async_set) q <= {N{init_val}};
    else                q <= q_d;
  end

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en && !force_init) |=> (force_init || $stable(q)));

  assert_force_R6: assert property (@(posedge clk) disable iff (!rst_n)
    force_init |=> (q == {N{$past(init_val)}}));
endmodule

// File: rtl/lut_tile.sv
module lut_tile
  import lut_tile_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic                 rst_n,
  input  logic                 clk,
  input  logic                 clk_en,
  input  logic                 force_init,
  input  logic                 ctl_sel,
  input  logic [ADDR_W:0]      in_a,
  input  logic [ADDR_W:0]      in_b,
  input  logic [NUM_LUT-1:0]   wr_data,
  input  logic                 carry_in,
  input  logic                 cfg_shift,
  input  logic                 cfg_bit,
  output logic [NUM_LUT:0]     dout,
  output logic                 carry_out
);
  localparam int LUT_BITS = NUM_LUT * (1 << ADDR_W);

  logic [LUT_BITS-1:0] lut_bits;
  ctrl_t               ctrl;
  logic [NUM_LUT-1:0]  res, q;
  logic                aux;

  lut_tile_cfg #(.ADDR_W(ADDR_W)) cfg_i (
    .clk(clk), .rst_n(rst_n), .cfg_shift(cfg_shift), .cfg_bit(cfg_bit),
    .wr_en(ctl_sel), .wr_addr(in_a[ADDR_W-1:0]), .wr_data(wr_data),
    .lut_bits(lut_bits), .ctrl(ctrl)
  );

  lut_tile_logic #(.ADDR_W(ADDR_W)) logic_i (
    .lut_bits(lut_bits), .ctrl(ctrl), .op_a(in_a), .op_b(in_b),
    .wdata(wr_data), .wr_en(ctl_sel), .cin(carry_in),
    .res(res), .aux(aux), .cout(carry_out)
  );

  lut_tile_regs #(.N(NUM_LUT)) regs_i (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .force_init(force_init),
    .force_async(ctrl.force_async), .init_val(ctrl.init_val),
    .d(res), .q(q)
  );

  assign dout = {aux, ctrl.bypass ? res : q};

  assert_adder_sum_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.mode == MODE_ADDER && ctrl.bypass)
      |-> ({carry_out, dout[NUM_LUT-1:0]} ==
           ({1'b0, in_a[NUM_LUT-1:0]} + {1'b0, in_b[NUM_LUT-1:0]} + {{NUM_LUT{1'b0}}, carry_in})));

  assert_adder_aux_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.mode == MODE_ADDER) |-> (dout[NUM_LUT] == 1'b0));
endmodule

// File: tb/lut_tile_tb_top.sv
module lut_tile_tb_top;
  localparam int PERIOD = 10;
  localparam logic [63:0] TBL = {16'hAAAA, 16'hCCCC, 16'hF0F0, 16'hFF00};

  // {width[1:0], in_a[4:0], in_b[4:0], expected dout[4:0]} for logic mode, bypass on
  localparam logic [16:0] VEC [7] = '{
    {2'd0, 5'b01000, 5'b00001, 5'b11001},
    {2'd0, 5'b00100, 5'b00010, 5'b00110},
    {2'd1, 5'b10100, 5'b10001, 5'b10011},
    {2'd1, 5'b01000, 5'b10010, 5'b10001},
    {2'd2, 5'b10001, 5'b10000, 5'b10001},
    {2'd2, 5'b10100, 5'b00000, 5'b10001},
    {2'd2, 5'b00100, 5'b10000, 5'b00000}
  };

  logic       clk = 1'b0;
  logic       rst_n, clk_en, force_init, ctl_sel, carry_in, cfg_shift, cfg_bit;
  logic [4:0] in_a, in_b, dout;
  logic [3:0] wr_data;
  logic       carry_out;
  int         checks = 0;
  int         errors = 0;

  always #(PERIOD/2) clk = ~clk;

  lut_tile dut_i (
    .rst_n(rst_n), .clk(clk), .clk_en(clk_en), .force_init(force_init),
    .ctl_sel(ctl_sel), .in_a(in_a), .in_b(in_b), .wr_data(wr_data),
    .carry_in(carry_in), .cfg_shift(cfg_shift), .cfg_bit(cfg_bit),
    .dout(dout), .carry_out(carry_out)
  );

  task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // ctrl fields: {wr_through, init_val, force_async, bypass, width[1:0], mode[1:0]}
  function automatic logic [71:0] mk_cfg(input logic [63:0] t, input logic wt, input logic iv,
                                         input logic fa, input logic bp, input logic [1:0] w,
                                         input logic [1:0] m);
    return {wt, iv, fa, bp, w, m, t};
  endfunction

  task automatic load_cfg(input logic [71:0] w);
    for (int i = 71; i >= 0; i--) begin
      @(negedge clk);
      cfg_shift = 1'b1;
      cfg_bit   = w[i];
    end
    @(negedge clk);
    cfg_shift = 1'b0;
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; clk_en = 1'b0; force_init = 1'b0; ctl_sel = 1'b0; carry_in = 1'b0;
    cfg_shift = 1'b0; cfg_bit = 1'b0; in_a = '0; in_b = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    check("R1 in reset", {carry_out, dout}, 6'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 after reset", {carry_out, dout}, 6'd0);

    // R2: table 0 entry 0 only, four-input logic, bypass
    load_cfg(mk_cfg(64'h1, 0, 0, 0, 1, 2'd0, 2'd0));
    in_a = 5'd0; #2;
    check("R2 entry0 set", {5'd0, dout[0]}, 6'd1);
    @(negedge clk); in_a = 5'd1; #2;
    check("R2 entry1 clear", {5'd0, dout[0]}, 6'd0);

    // R3: table of logic vectors
    for (int v = 0; v < 7; v++) begin
      load_cfg(mk_cfg(TBL, 0, 0, 0, 1, VEC[v][16:15], 2'd0));
      in_a = VEC[v][14:10]; in_b = VEC[v][9:5]; #2;
      check("R3 logic vector", {carry_out, dout}, {1'b0, VEC[v][4:0]});
    end

    // R4: exhaustive adder, tables loaded with non-zero contents
    load_cfg(mk_cfg(TBL, 0, 0, 0, 1, 2'd0, 2'd1));
    for (int n = 0; n < 512; n++) begin
      @(negedge clk);
      in_a = {1'b0, 4'(n[3:0])}; in_b = {1'b0, 4'(n[7:4])}; carry_in = n[8]; #2;
      check("R4 adder", {carry_out, dout},
            {(5'(n[3:0]) + 5'(n[7:4]) + 5'(n[8])), 1'b0} >> 0 == 0 ? 6'd0 :
            {1'b0, 5'(0)} | {6'((n[3:0] + n[7:4] + n[8]) >> 4), 1'b0, 4'(n[3:0] + n[7:4] + n[8])});
    end
    carry_in = 1'b0;

    // R5: registered four-input logic
    load_cfg(mk_cfg(TBL, 0, 0, 0, 0, 2'd0, 2'd0));
    in_a = 5'd0; in_b = 5'd0; clk_en = 1'b1;
    @(negedge clk);
    in_a = 5'b01100; in_b = 5'b00011; #2;
    check("R5 before edge", {1'b0, dout}, 6'b010000);
    @(posedge clk); #1;
    check("R5 captured", {1'b0, dout}, 6'b011111);
    @(negedge clk);
    clk_en = 1'b0; in_a = 5'd0; in_b = 5'd0;
    @(posedge clk); #1;
    check("R5 hold ce low", {2'b0, dout[3:0]}, 6'b001111);

    // R6: synchronous force to 0, overriding a low clock enable
    @(negedge clk);
    force_init = 1'b1; #2;
    check("R6 before edge", {2'b0, dout[3:0]}, 6'b001111);
    @(posedge clk); #1;
    check("R6 forced", {2'b0, dout[3:0]}, 6'd0);
    @(negedge clk); force_init = 1'b0;

    // R7: asynchronous force to 1
    load_cfg(mk_cfg(TBL, 0, 1, 1, 0, 2'd0, 2'd0));
    #1; force_init = 1'b1; #1;
    check("R7 async force", {2'b0, dout[3:0]}, 6'b001111);
    @(negedge clk); force_init = 1'b0;

    // R8: single-port RAM, synchronous write
    load_cfg(mk_cfg(TBL, 0, 0, 0, 1, 2'd0, 2'd2));
    in_a = 5'd5; wr_data = 4'h3; ctl_sel = 1'b1; #2;
    check("R8 read before write", {2'b0, dout[3:0]}, 6'h0A);
    @(posedge clk); #1;
    check("R8 written", {2'b0, dout[3:0]}, 6'h03);
    @(negedge clk); ctl_sel = 1'b0; wr_data = 4'hF;
    @(posedge clk); #1;
    check("R8 read-only", {2'b0, dout[3:0]}, 6'h03);
    check("R8 aux low", {5'd0, dout[4]}, 6'd0);

    // R9: write-through
    load_cfg(mk_cfg(TBL, 1, 0, 0, 1, 2'd0, 2'd2));
    in_a = 5'd7; wr_data = 4'h6; ctl_sel = 1'b1; #2;
    check("R9 write-through", {2'b0, dout[3:0]}, 6'h06);
    @(negedge clk); ctl_sel = 1'b0; wr_data = 4'h0; #2;
    check("R9 stored", {2'b0, dout[3:0]}, 6'h06);

    // R10: dual-port RAM
    load_cfg(mk_cfg(TBL, 0, 0, 0, 1, 2'd0, 2'd3));
    in_a = 5'd0; in_b = 5'd3; #2;
    check("R10 port B initial", {2'b0, dout[3:0]}, 6'b001100);
    @(negedge clk);
    in_a = 5'd3; wr_data = 4'b0010; ctl_sel = 1'b1;
    @(negedge clk);
    ctl_sel = 1'b0; in_a = 5'd0; #2;
    check("R10 port B after write", {2'b0, dout[3:0]}, 6'b001000);
    @(negedge clk); in_a = 5'd3; #2;
    check("R10 port A after write", {2'b0, dout[3:0]}, 6'b001010);

    finish_run();
  end
endmodule